// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits behind the write port of a small parallel NOR-style flash model. It interprets each accepted bus write as one step of a multi-write command sequence. It keeps a write-step counter, a latched command, an 8-bit status register and a word counter for buffered writes. Program and sector-erase operations act on an internal byte array. A read path elsewhere uses the current mode output to decide whether it returns array data, status, identification or query data. For that purpose the block also offers a plain array read port.

The array is `MEM_BYTES` bytes. It is divided into erase sectors of `SECTOR_BYTES` bytes, and a data word is one byte. A strap input marks the part as read-only. In that case program and erase attempts leave the array alone and raise error bits in the status register instead. A sector erase does not finish in one cycle. It fills the sector with 0xFF at one byte per clock while `busy` is high, and bus writes that arrive during that time are dropped.

Top module: `nor_cmd_engine`

## Requirements
- R1: While `rstN` is low, `statusOut` becomes 0x80 and `modeOut` becomes 0x00 (read-array). `busy` is 0 and every array byte reads 0x00.
- R2: In the idle step, code 0x40 or 0x10 arms a program. The next write stores `wrData` at `wrAddr`, ORs 0x80 (ready, bit 7) into status and returns the step counter to idle. `modeOut` keeps showing the program code.
- R3: With `roStrap` high, the data write of a program leaves the array unchanged and ORs 0x90 into status (program error is bit 4, plus ready).
- R4: Idle code 0x20 erases the sector that holds `wrAddr`. The address is aligned down to `SECTOR_BYTES`, and the sector is filled with 0xFF over exactly `SECTOR_BYTES` cycles with `busy` high. No other sector is touched. Ready is set, and `modeOut` shows 0x20. With `roStrap` high the array is untouched, `busy` stays low and status gains 0xA0 (erase error is bit 5, plus ready).
- R5: After an erase, a write of 0xD0 returns to the idle step with `modeOut` left at 0x20 and ready set. Any other value, 0xFF included, selects read-array mode (0x00).
- R6: Bus writes that arrive while `busy` is high change neither the array, the status nor the mode.
- R7: Idle code 0x50 clears status to 0x00 and selects read-array mode. Idle codes 0xFF, 0xF0 and 0x00 select read-array mode.
- R8: Idle codes 0x70 (status read) and 0x90 (ID read) set `modeOut` to the code without advancing the step counter, so the next write is decoded as a new command.
- R9: Idle code 0x98 selects query mode. A following 0xFF selects read-array mode, and any other following write leaves query mode in force.
- R10: Idle code 0x60 starts a lock sequence. A second write of 0xD0 or 0x01 sets ready and returns to idle with `modeOut` still 0x60. Any other second write selects read-array mode.
- R11: Idle code 0xE8 sets ready and starts a buffered write. The next write is a count N taken from the low `CNT_W` bits of `wrData`. Exactly N+1 data writes follow, each storing one byte at its address. After those, 0xD0 returns to idle with `modeOut` still 0xE8, and any other value selects read-array mode without undoing the stored bytes.
- R12: An idle write of any code not named in R2 to R11 selects read-array mode.
- R13: With `roStrap` high, buffered data writes leave the array unchanged and OR 0x90 into status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| roStrap | input | 1 | Read-only strap: program and erase become error flags |
| wrEn | input | 1 | One-cycle bus write strobe |
| wrAddr | input | ADDR_W | Byte address of the bus write |
| wrData | input | 8 | Bus write data or command code |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | 8 | Array byte at `rdAddr` (combinational) |
| statusOut | output | 8 | Status register |
| modeOut | output | 8 | Latched command, 0x00 for read-array |
| busy | output | 1 | Sector fill in progress |

## Verification
Every command step, status update and single-byte store is registered at the clock edge that samples `wrEn`. Its result is due one edge later, so the bench drives each write at a falling edge and samples `modeOut`, `statusOut` and the array at the next falling edge. An erase raises `busy` at that same edge. The 0xFF fill then completes `SECTOR_BYTES` edges after it, so the bench counts falling edges with `busy` high, expects exactly `SECTOR_BYTES`, and reads the sector only after `busy` drops. A write placed in the first busy cycle is checked at the following falling edge, where status and mode must be unchanged.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  // command codes seen on the data bus
  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_PROG_A   = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_PROG_B   = 8'h40;
  localparam logic [7:0] CMD_CLEAR    = 8'h50;
  localparam logic [7:0] CMD_LOCK     = 8'h60;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_BUFFER   = 8'hE8;
  localparam logic [7:0] CMD_READ_ALT = 8'hF0;
  localparam logic [7:0] CMD_ARRAY    = 8'hFF;
  localparam logic [7:0] CODE_GO      = 8'hD0;
  localparam logic [7:0] CODE_UNLOCK  = 8'h01;

  // status bits
  localparam logic [7:0] ST_READY     = 8'h80;
  localparam logic [7:0] ST_ERASE_ERR = 8'h20;
  localparam logic [7:0] ST_PROG_ERR  = 8'h10;

  typedef struct packed {
    logic prog;   // store wrData at wrAddr this cycle
    logic erase;  // start a sector fill around wrAddr
  } strobe_t;

endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       roStrap,
  input  logic       busy,
  input  logic [7:0] wrData,
  output strobe_t    strobe,
  output logic [7:0] statusQ,
  output logic [7:0] modeQ
);

  typedef enum logic [1:0] {CY_IDLE, CY_ARG, CY_DATA, CY_CONFIRM} cycle_e;

  cycle_e             cycQ, cycD;
  logic [7:0]         cmdD, statD;
  logic [CNT_W-1:0]   cntQ, cntD;
  logic               take, goRead;

  assign take = wrEn && !busy;

  always_comb begin
    cycD   = cycQ;
    cmdD   = modeQ;
    statD  = statusQ;
    cntD   = cntQ;
    strobe = '0;
    goRead = 1'b0;
    if (take) begin
      unique case (cycQ)
        CY_IDLE: begin
          case (wrData)
            CMD_READ, CMD_READ_ALT, CMD_ARRAY: goRead = 1'b1;
            CMD_PROG_A, CMD_PROG_B, CMD_LOCK, CMD_QUERY: begin
              cycD = CY_ARG;
              cmdD = wrData;
            end
            CMD_ERASE: begin
              if (roStrap) statD = statD | ST_ERASE_ERR;
              else         strobe.erase = 1'b1;
              statD = statD | ST_READY;
              cycD  = CY_ARG;
              cmdD  = wrData;
            end
            CMD_CLEAR: begin
              statD  = '0;
              goRead = 1'b1;
            end
            CMD_STATUS, CMD_IDENT: cmdD = wrData;
            CMD_BUFFER: begin
              statD = statD | ST_READY;
              cycD  = CY_ARG;
              cmdD  = wrData;
            end
            default: goRead = 1'b1;
          endcase
        end
        CY_ARG: begin
          case (modeQ)
            CMD_PROG_A, CMD_PROG_B: begin
              if (roStrap) statD = statD | ST_PROG_ERR;
              else         strobe.prog = 1'b1;
              statD = statD | ST_READY;
              cycD  = CY_IDLE;
            end
            CMD_ERASE: begin
              if (wrData == CODE_GO) begin
                statD = statD | ST_READY;
                cycD  = CY_IDLE;
              end else goRead = 1'b1;
            end
            CMD_LOCK: begin
              if (wrData == CODE_GO || wrData == CODE_UNLOCK) begin
                statD = statD | ST_READY;
                cycD  = CY_IDLE;
              end else goRead = 1'b1;
            end
            CMD_QUERY: begin
              if (wrData == CMD_ARRAY) goRead = 1'b1;
            end
            CMD_BUFFER: begin
              cntD = wrData[CNT_W-1:0];
              cycD = CY_DATA;
            end
            default: goRead = 1'b1;
          endcase
        end
        CY_DATA: begin
          if (modeQ == CMD_BUFFER) begin
            if (roStrap) statD = statD | ST_PROG_ERR;
            else         strobe.prog = 1'b1;
            statD = statD | ST_READY;
            if (cntQ == '0) begin
              cycD = CY_CONFIRM;
              if (roStrap) statD = statD | ST_PROG_ERR;
            end
            cntD = cntQ - 1'b1;
          end else goRead = 1'b1;
        end
        default: begin
          if (modeQ == CMD_BUFFER && wrData == CODE_GO) begin
            statD = statD | ST_READY;
            cycD  = CY_IDLE;
          end else goRead = 1'b1;
        end
      endcase
      if (goRead) begin
        cycD = CY_IDLE;
        cmdD = CMD_READ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycQ    <= CY_IDLE;
      modeQ   <= CMD_READ;
      statusQ <= ST_READY;
      cntQ    <= '0;
    end else begin
      cycQ    <= cycD;
      modeQ   <= cmdD;
      statusQ <= statD;
      cntQ    <= cntD;
    end
  end

endmodule

// File: rtl/nor_cmd_store.sv
module nor_cmd_store
  import nor_cmd_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int SECTOR_BYTES = 64,
  localparam int ADDR_W      = $clog2(MEM_BYTES),
  localparam int SECT_W      = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              busy
);

  logic [7:0]               mem [MEM_BYTES];
  logic [SECT_W-1:0]        idxQ;
  logic [ADDR_W-SECT_W-1:0] baseQ;
  logic                     busyQ;

  assign busy   = busyQ;
  assign rdData = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      baseQ <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else begin
      if (busyQ) begin
        mem[{baseQ, idxQ}] <= 8'hFF;
        idxQ <= idxQ + 1'b1;
        if (idxQ == SECT_W'(SECTOR_BYTES - 1)) busyQ <= 1'b0;
      end else if (strobe.erase) begin
        busyQ <= 1'b1;
        idxQ  <= '0;
        baseQ <= wrAddr[ADDR_W-1:SECT_W];
      end
      if (strobe.prog) mem[wrAddr] <= wrData;
    end
  end

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_cmd_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int SECTOR_BYTES = 64,
  parameter int CNT_W        = 4,
  localparam int ADDR_W      = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              roStrap,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [7:0]        statusOut,
  output logic [7:0]        modeOut,
  output logic              busy
);

  strobe_t strobe;

  nor_cmd_ctrl #(.CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .roStrap(roStrap), .busy(busy),
    .wrData(wrData), .strobe(strobe), .statusQ(statusOut), .modeQ(modeOut)
  );

  nor_cmd_store #(.MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy)
  );

endmodule

// File: rtl/nor_cmd_checker.sv
module nor_cmd_checker #(
  parameter int SECTOR_BYTES = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] statusOut,
  input logic [7:0] modeOut,
  input logic       busy
);

  function automatic logic isKnown(input logic [7:0] c);
    case (c)
      8'h00, 8'h10, 8'h20, 8'h40, 8'h50, 8'h60, 8'h70,
      8'h90, 8'h98, 8'hE8, 8'hF0, 8'hFF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  int runQ;
  always_ff @(posedge clk) begin
    if (!rstN)     runQ <= 0;
    else if (busy) runQ <= runQ + 1;
    else           runQ <= 0;
  end

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (statusOut == 8'h80 && modeOut == 8'h00 && !busy));

  // R6: writes during a fill are dropped
  p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> ($stable(statusOut) && $stable(modeOut)));

  // R4: a fill starts with ready already set
  p_erase_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> statusOut[7]);

  // R4: a fill never outlasts one sector
  p_fill_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    runQ <= SECTOR_BYTES);

  // R7: clear status from read-array mode
  p_clear_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && modeOut == 8'h00 && wrData == 8'h50)
      |=> (statusOut == 8'h00 && modeOut == 8'h00));

  // R12: unknown code from read-array mode stays in read-array mode
  p_unknown_code_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && modeOut == 8'h00 && !isKnown(wrData)) |=> modeOut == 8'h00);

endmodule

bind nor_cmd_engine nor_cmd_checker #(.SECTOR_BYTES(SECTOR_BYTES)) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .statusOut(statusOut), .modeOut(modeOut), .busy(busy)
);

// File: tb/nor_cmd_engine_test.sv
module nor_cmd_engine_test;

  localparam int MEM_BYTES = 256;
  localparam int SECTOR    = 64;
  localparam int ADDR_W    = $clog2(MEM_BYTES);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              roStrap = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData, statusOut, modeOut;
  logic              busy;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  nor_cmd_engine #(.MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR), .CNT_W(4)) uut (
    .clk(clk), .rstN(rstN), .roStrap(roStrap), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .statusOut(statusOut),
    .modeOut(modeOut), .busy(busy)
  );

  // {data, expected mode, expected status}, all at address 0
  localparam int NVEC = 18;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h50_00_00,  // R7 clear
    24'h70_70_00,  // R8 status mode
    24'h90_90_00,  // R8 decoded as command
    24'hF0_00_00,  // R7
    24'h98_98_00,  // R9
    24'h12_98_00,  // R9 stays
    24'hFF_00_00,  // R9 leave
    24'h60_60_00,  // R10
    24'h01_60_80,  // R10 unlock
    24'h50_00_00,  // R7
    24'h60_60_00,  // R10
    24'hD0_60_80,  // R10 confirm
    24'h50_00_00,  // R7
    24'h60_60_00,  // R10
    24'h33_00_00,  // R10 other value
    24'hAB_00_00,  // R12 unknown
    24'h70_70_00,  // R8
    24'h00_00_00   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] d, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; wrAddr = a;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    rdAddr = a;
    #0.1;
    check(req, rdData, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 status", statusOut, 8'h80);
    check("R1 mode", modeOut, 8'h00);
    check("R1 busy", busy, 0);
    peek("R1 array", 8'h05, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      doWrite(VEC[i][23:16], '0);
      check($sformatf("table %0d mode", i), modeOut, VEC[i][15:8]);
      check($sformatf("table %0d status", i), statusOut, VEC[i][7:0]);
    end

    // R2 program
    doWrite(8'h50, 0);
    doWrite(8'h40, 0); doWrite(8'h5A, 8'h05);
    peek("R2 stored", 8'h05, 8'h5A);
    check("R2 ready", statusOut, 8'h80);
    check("R2 mode", modeOut, 8'h40);
    doWrite(8'h10, 0); doWrite(8'h3C, 8'h46);
    peek("R2 alt code", 8'h46, 8'h3C);
    doWrite(8'h40, 0); doWrite(8'h11, 8'h3F);
    doWrite(8'h40, 0); doWrite(8'h22, 8'h80);

    // R4 erase sector 1, R6 ignored write during fill
    doWrite(8'h50, 0);
    doWrite(8'h20, 8'h47);
    check("R4 busy", busy, 1);
    check("R4 ready", statusOut, 8'h80);
    doWrite(8'h50, 0);
    check("R6 status kept", statusOut, 8'h80);
    check("R6 mode kept", modeOut, 8'h20);
    while (busy) @(negedge clk);
    peek("R4 low end", 8'h40, 8'hFF);
    peek("R4 mid", 8'h46, 8'hFF);
    peek("R4 high end", 8'h7F, 8'hFF);
    peek("R4 below", 8'h3F, 8'h11);
    peek("R4 above", 8'h80, 8'h22);
    doWrite(8'hD0, 0);
    check("R5 confirm mode", modeOut, 8'h20);
    doWrite(8'h70, 0);
    check("R5 back to idle", modeOut, 8'h70);

    // R4 fill length, R5 other value
    doWrite(8'h20, 8'hC5);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R4 fill cycles", n, SECTOR);
    peek("R4 sector 3", 8'hC0, 8'hFF);
    doWrite(8'h55, 0);
    check("R5 abort mode", modeOut, 8'h00);

    // R11 buffered write, count masked to 4 bits
    doWrite(8'h50, 0);
    doWrite(8'hE8, 0);
    check("R11 ready", statusOut, 8'h80);
    check("R11 mode", modeOut, 8'hE8);
    doWrite(8'hF2, 0);
    doWrite(8'hA1, 8'h10);
    doWrite(8'hA2, 8'h11);
    doWrite(8'hA3, 8'h12);
    check("R11 still buffering", modeOut, 8'hE8);
    doWrite(8'hD0, 8'h13);
    check("R11 confirm mode", modeOut, 8'hE8);
    peek("R11 word0", 8'h10, 8'hA1);
    peek("R11 word2", 8'h12, 8'hA3);
    peek("R11 no extra word", 8'h13, 8'h00);
    doWrite(8'h70, 0);
    check("R11 idle after confirm", modeOut, 8'h70);
    doWrite(8'hE8, 0); doWrite(8'h00, 0); doWrite(8'hB7, 8'h20);
    doWrite(8'h33, 0);
    check("R11 abort mode", modeOut, 8'h00);
    peek("R11 abort keeps data", 8'h20, 8'hB7);

    // R3 / R4 / R13 read-only strap
    roStrap = 1'b1;
    doWrite(8'h50, 0);
    doWrite(8'h40, 0); doWrite(8'h99, 8'h05);
    peek("R3 untouched", 8'h05, 8'h5A);
    check("R3 status", statusOut, 8'h90);
    doWrite(8'h50, 0);
    doWrite(8'h20, 8'h00);
    check("R4 ro status", statusOut, 8'hA0);
    check("R4 ro no busy", busy, 0);
    peek("R4 ro untouched", 8'h3F, 8'h11);
    doWrite(8'hFF, 0);
    check("R5 ff after erase", modeOut, 8'h00);
    doWrite(8'h50, 0);
    doWrite(8'hE8, 0); doWrite(8'h00, 0); doWrite(8'h77, 8'h30);
    peek("R13 untouched", 8'h30, 8'h00);
    check("R13 status", statusOut, 8'h90);
    doWrite(8'hD0, 0);
    check("R13 confirm mode", modeOut, 8'hE8);
    roStrap = 1'b0;

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 status again", statusOut, 8'h80);
    check("R1 mode again", modeOut, 8'h00);
    peek("R1 array cleared", 8'h05, 8'h00);
    rstN = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule